// File: doc/BRIEF.md
# Gated Direct-Count Frequency Meter

This block measures the frequency of a logic-level input, such as the output of an external comparator. The input is first brought into the clock domain through a two-stage synchronizer. The block then counts every low-to-high transition of that signal during a gate window. The window lasts a whole number of seconds, chosen by a 4-bit input. One second is a parameterised number of system clock cycles.

Windows follow each other with no gap. When a window closes, the block captures the raw transition count and an overflow indication. A sequential restoring divider then divides the count by the gate length. The results are published together with a one-cycle valid strobe, and that strobe comes well before the next window closes.

Direct counting is uncertain by one count, because the input phase is unknown relative to the window. A longer gate therefore gives a smaller relative error.

Top module: `freq_meter`

## Requirements
- R1: Only rising transitions of the synchronised input are counted. Falling transitions and steady levels add nothing to the count. For example, a 30 Hz input over a 2 s gate reports raw_count 60.
- R2: freq_out equals raw_count divided by the gate length in seconds, rounded down. For example, a 40 Hz input over a 2 s gate reports raw_count 80 and freq_out 40.
- R3: A gate_sec value of 0 is treated as a gate of 1 second.
- R4: A window lasts gate_sec × CYC_PER_SEC clock cycles, and windows follow each other back to back. With a steady gate setting, consecutive result_valid pulses are exactly that many cycles apart.
- R5: The crossing count saturates at 2^CNT_W−1 and does not wrap. ovf_out is 1 with a result whose window saw a rising transition while the count was already at that maximum, and ovf_out is 0 otherwise.
- R6: result_valid is high for exactly one cycle per window. raw_count, freq_out and ovf_out change only in that same cycle.
- R7: A synchronous active-high rst clears raw_count, freq_out, ovf_out and result_valid to 0 and starts a fresh window.
- R8: For an input whose period does not divide the window evenly, raw_count is the window length divided by the period, either rounded down or rounded up. This is the ±1 count uncertainty of direct counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous logic-level signal to be measured |
| gate_sec | input | GATE_W | Gate length in seconds, sampled at the start of each window (0 is treated as 1) |
| raw_count | output | CNT_W | Rising transitions counted in the last completed window |
| freq_out | output | CNT_W | raw_count divided by the gate length |
| ovf_out | output | 1 | The count of the last window saturated |
| result_valid | output | 1 | One-cycle strobe marking new results |

## Verification
A wrong count in the window counter, or a lost boundary edge, shows up at raw_count in the very next result. Such an error moves the count off the exact values that periodic inputs give, for example 60 or 80. A fault in the gate timer, or a gate value that is not captured, shows up in two places: the spacing between result_valid pulses, and a freq_out that no longer equals the input rate. A broken divider step gives a freq_out that disagrees with raw_count divided by the gate length. Each of these errors is visible within one window plus the divider latency after the stimulus. A counter that wraps instead of saturating shows a small raw_count and a clear ovf_out on the narrow-counter instance.

// File: rtl/fm_pkg.sv
package fm_pkg;
  // A gate of zero seconds is promoted to one second
  function automatic logic [3:0] fix_gate(input logic [3:0] g);
    return (g == 4'd0) ? 4'd1 : g;
  endfunction
endpackage

// File: rtl/fm_sync_edge.sv
module fm_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;

  // R1: two rising flags can never be adjacent
  rise_gap_chk: assert property (@(posedge clk) disable iff (rst) rise |=> !rise);
endmodule

// File: rtl/fm_gate_timer.sv
module fm_gate_timer #(
  parameter int CYC_PER_SEC = 1000,
  parameter int GATE_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GATE_W-1:0] gate_sec,
  output logic              win_end,
  output logic [GATE_W-1:0] cur_gate
);
  import fm_pkg::*;
  localparam int TICK_W = (CYC_PER_SEC > 1) ? $clog2(CYC_PER_SEC) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CYC_PER_SEC - 1);

  logic [TICK_W-1:0] tick;
  logic [GATE_W-1:0] secs;

  assign win_end = (tick == TICK_LAST) && (secs == cur_gate - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick     <= '0;
      secs     <= '0;
      cur_gate <= fix_gate(gate_sec);
    end else if (win_end) begin
      tick     <= '0;
      secs     <= '0;
      cur_gate <= fix_gate(gate_sec);
    end else if (tick == TICK_LAST) begin
      tick <= '0;
      secs <= secs + 1'b1;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  // R3: the captured gate length is never zero
  gate_nonzero_chk: assert property (@(posedge clk) disable iff (rst) cur_gate != '0);
  // R4: the gate length is held for the whole window
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(cur_gate));
endmodule

// File: rtl/fm_edge_counter.sv
module fm_edge_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             win_end,
  output logic [CNT_W-1:0] cap_cnt,
  output logic             cap_ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             ovf_r;
  logic             full;

  assign full = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      ovf_r   <= 1'b0;
      cap_cnt <= '0;
      cap_ovf <= 1'b0;
    end else if (win_end) begin
      cap_cnt <= cnt;
      cap_ovf <= ovf_r;
      cnt     <= rise ? CNT_W'(1) : '0;
      ovf_r   <= 1'b0;
    end else if (rise) begin
      if (full) ovf_r <= 1'b1;
      else      cnt   <= cnt + 1'b1;
    end
  end

  // R5: a full count stays full until the window closes
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !win_end) |=> full);
endmodule

// File: rtl/fm_divider.sv
module fm_divider #(
  parameter int CNT_W  = 32,
  parameter int GATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  dvd,
  input  logic [GATE_W-1:0] dvs,
  output logic [CNT_W-1:0]  quo,
  output logic              done
);
  localparam int STEP_W = $clog2(CNT_W + 1);

  logic [GATE_W-1:0] rem;
  logic [GATE_W-1:0] dvs_r;
  logic [STEP_W-1:0] step;
  logic              busy;
  logic [GATE_W:0]   rem_sh;
  logic              fits;

  assign rem_sh = {rem, quo[CNT_W-1]};
  assign fits   = (rem_sh >= {1'b0, dvs_r});

  always_ff @(posedge clk) begin
    if (rst) begin
      quo   <= '0;
      rem   <= '0;
      dvs_r <= '0;
      step  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quo   <= dvd;
        rem   <= '0;
        dvs_r <= dvs;
        step  <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        rem  <= fits ? GATE_W'(rem_sh - {1'b0, dvs_r}) : rem_sh[GATE_W-1:0];
        quo  <= {quo[CNT_W-2:0], fits};
        step <= step + 1'b1;
        if (step == STEP_W'(CNT_W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R2: the partial remainder stays below the divisor
  rem_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rem < dvs_r));
endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int CYC_PER_SEC = 1000,
  parameter int CNT_W       = 32,
  parameter int GATE_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sig_in,
  input  logic [GATE_W-1:0] gate_sec,
  output logic [CNT_W-1:0]  raw_count,
  output logic [CNT_W-1:0]  freq_out,
  output logic              ovf_out,
  output logic              result_valid
);
  logic              rise;
  logic              win_end;
  logic              div_start;
  logic              div_done;
  logic [GATE_W-1:0] cur_gate;
  logic [GATE_W-1:0] div_gate;
  logic [CNT_W-1:0]  cap_cnt;
  logic              cap_ovf;
  logic [CNT_W-1:0]  quo;

  fm_sync_edge u_sync (
    .clk(clk), .rst(rst), .async_in(sig_in), .rise(rise)
  );

  fm_gate_timer #(.CYC_PER_SEC(CYC_PER_SEC), .GATE_W(GATE_W)) u_timer (
    .clk(clk), .rst(rst), .gate_sec(gate_sec), .win_end(win_end), .cur_gate(cur_gate)
  );

  fm_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .rise(rise), .win_end(win_end),
    .cap_cnt(cap_cnt), .cap_ovf(cap_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_start <= 1'b0;
      div_gate  <= '0;
    end else begin
      div_start <= win_end;
      if (win_end) div_gate <= cur_gate;
    end
  end

  fm_divider #(.CNT_W(CNT_W), .GATE_W(GATE_W)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .dvd(cap_cnt), .dvs(div_gate),
    .quo(quo), .done(div_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_count    <= '0;
      freq_out     <= '0;
      ovf_out      <= 1'b0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= div_done;
      if (div_done) begin
        raw_count <= cap_cnt;
        freq_out  <= quo;
        ovf_out   <= cap_ovf;
      end
    end
  end

  // R6: the valid strobe lasts a single cycle
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);
  // R6: the results hold steady between strobes
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !div_done |=> $stable(raw_count) && $stable(freq_out) && $stable(ovf_out));
endmodule

// File: tb/test_freq_meter.sv
module test_freq_meter;
  localparam int CPS = 120;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sig_in = 1'b0;
  logic [3:0]  gate_sec = 4'd2;
  logic [31:0] raw_count, freq_out;
  logic        ovf_out, result_valid;
  logic [5:0]  s_raw, s_freq;
  logic        s_ovf, s_valid;

  int checks = 0;
  int errors = 0;
  int period = 0;
  int ph = 0;

  always #2 clk = ~clk;

  freq_meter #(.CYC_PER_SEC(CPS), .CNT_W(32), .GATE_W(4)) i_freq_meter (
    .clk(clk), .rst(rst), .sig_in(sig_in), .gate_sec(gate_sec),
    .raw_count(raw_count), .freq_out(freq_out), .ovf_out(ovf_out),
    .result_valid(result_valid)
  );

  freq_meter #(.CYC_PER_SEC(CPS), .CNT_W(6), .GATE_W(4)) i_freq_meter_sat (
    .clk(clk), .rst(rst), .sig_in(sig_in), .gate_sec(gate_sec),
    .raw_count(s_raw), .freq_out(s_freq), .ovf_out(s_ovf),
    .result_valid(s_valid)
  );

  // Periodic stimulus: one high cycle every 'period' cycles, driven at negedge
  initial begin
    forever begin
      @(negedge clk);
      if (period == 0) begin
        ph = 0;
        sig_in = 1'b0;
      end else begin
        ph = (ph + 1 >= period) ? 0 : ph + 1;
        sig_in = (ph == 0);
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_main(output int cycles);
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!result_valid && cycles < 5000);
  endtask

  task automatic wait_sat();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!s_valid && n < 5000);
  endtask

  // Apply a setting, let two results go by, return at the third
  task automatic settle(input int per, input logic [3:0] g);
    int c;
    period = per;
    gate_sec = g;
    wait_main(c);
    wait_main(c);
    wait_main(c);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 raw_count", raw_count, 0);
    check("R7 freq_out", freq_out, 0);
    check("R7 ovf_out", ovf_out, 0);
    check("R7 result_valid", result_valid, 0);
    rst = 1'b0;
  endtask

  task automatic t_30hz();
    settle(4, 4'd2);
    check("R1 raw 30Hz/2s", raw_count, 60);
    check("R2 freq 30Hz/2s", freq_out, 30);
    check("R5 no ovf", ovf_out, 0);
    @(negedge clk);
    check("R6 single pulse", result_valid, 0);
  endtask

  task automatic t_40hz();
    settle(3, 4'd2);
    check("R1 raw 40Hz/2s", raw_count, 80);
    check("R2 freq 40Hz/2s", freq_out, 40);
  endtask

  task automatic t_gate_zero();
    settle(3, 4'd0);
    check("R3 raw gate0", raw_count, 40);
    check("R3 freq gate0", freq_out, 40);
  endtask

  task automatic t_gate3_spacing();
    int c;
    settle(4, 4'd3);
    check("R1 raw 30Hz/3s", raw_count, 90);
    check("R2 freq 30Hz/3s", freq_out, 30);
    wait_main(c);
    check("R4 window spacing", c, 3 * CPS);
  endtask

  task automatic t_idle();
    settle(0, 4'd2);
    check("R1 raw idle", raw_count, 0);
    check("R2 freq idle", freq_out, 0);
  endtask

  task automatic t_uneven();
    settle(7, 4'd2);
    checks++;
    if (raw_count != 34 && raw_count != 35) begin
      errors++;
      $display("FAIL R8: actual %0d expected 34 or 35", raw_count);
    end
    check("R2 floor divide", freq_out, raw_count / 2);
  endtask

  task automatic t_saturate();
    settle(3, 4'd2);
    wait_sat();
    wait_sat();
    check("R5 sat raw", s_raw, 63);
    check("R5 sat ovf", s_ovf, 1);
    check("R2 sat freq", s_freq, 31);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_30hz();
    t_40hz();
    t_gate_zero();
    t_gate3_spacing();
    t_idle();
    t_uneven();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule